// File: doc/BRIEF.md
# Bulk-Synchronous Phase Sequencer

This block paces a group of processing elements through an endless loop of steps. Every step has three phases in a fixed order. First the elements compute on local data. Then they meet at a global barrier. Then they exchange data. Each element raises a request line on its own once its local work is done. The sequencer records that arrival and holds it. When the last element has arrived, the barrier opens and the whole group moves into the exchange phase.

While exchange is under way, each element reports that its traffic has finished on a done line. Once every element has reported, the sequencer returns to compute. It sends a one-cycle start pulse to all elements and advances a step counter. Globally the steps run strictly one after another, even though the work inside each step is parallel across the elements.

The current phase is broadcast on a two-bit bus. A sticky error flag catches an element that requests the barrier twice before the barrier has released.

Top module: `bsp_phase_seq`

## Requirements
- R1: After reset, the outputs are as follows: phase reads compute (0), startCompute is low, stepCount is 0, protoErr is low, and no arrivals or exchange completions are recorded.
- R2: The phase bus uses the codes 0 = compute, 1 = sync, 2 = exchange, and never shows 3. In compute, any bit of syncReq that is high at a clock edge moves the phase to sync at that edge.
- R3: Arrivals are held in a sticky per-element vector. The phase moves from sync to exchange on the clock edge after the edge that completes the vector, and never while any element is missing.
- R4: The arrival vector clears when the barrier releases. syncReq pulses seen during exchange are not recorded, so the next barrier again needs every element.
- R5: Exchange completions are held in a sticky per-element vector. The phase goes from exchange to compute on the edge after every element has asserted xchgDone. xchgDone outside exchange is ignored.
- R6: startCompute is high for exactly one cycle. That cycle is the first compute cycle after an exchange. Reset does not produce the pulse.
- R7: stepCount is 16 bits wide and increases by one, with wrap-around, on each return from exchange to compute. At no other time does it change.
- R8: A syncReq from an element whose arrival is already recorded, while the barrier has not yet released (including the release cycle), sets protoErr. protoErr stays set until reset and does not alter the phase sequence.
- R9: The parameter N sets the element count from 2 to 64. Exchange is entered only from sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncReq | input | N | Per-element "compute finished" request |
| xchgDone | input | N | Per-element exchange-complete indication |
| phase | output | 2 | Global phase: 0 compute, 1 sync, 2 exchange |
| startCompute | output | 1 | One-cycle pulse opening a new compute phase |
| stepCount | output | 16 | Number of completed steps, wrapping |
| protoErr | output | 1 | Sticky duplicate-request error |

## Verification
The hardest situations to reach are stale handshakes: a request or done pulse that arrives in the wrong phase and must leave no trace.

The stimulus reaches them in three ways:
- It drives every syncReq during an exchange and every xchgDone during compute.
- It then completes the following phase with only a partial set of elements. A leaked bit would therefore shorten that barrier or exchange by a visible cycle.
- It pulses a duplicate request exactly in the release cycle, where the arrival vector is full and about to clear.

// File: rtl/bsp_seq_pkg.sv
package bsp_seq_pkg;

  typedef enum logic [1:0] {
    PH_COMPUTE  = 2'd0,
    PH_SYNC     = 2'd1,
    PH_EXCHANGE = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic recordArr;
    logic clearArr;
    logic recordDone;
    logic clearDone;
    logic bumpStep;
  } seqStrobe_t;

endpackage

// File: rtl/bsp_seq_datapath.sv
module bsp_seq_datapath
  import bsp_seq_pkg::*;
#(
  parameter int N      = 8,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      syncReq,
  input  logic [N-1:0]      xchgDone,
  input  seqStrobe_t        strobe,
  output logic              anyReq,
  output logic              allArrived,
  output logic              allDone,
  output logic [STEP_W-1:0] stepCount,
  output logic              protoErr
);

  logic [N-1:0] arrV;
  logic [N-1:0] doneV;
  logic [N-1:0] dupHit;

  // one arrival slot and one done slot per element
  for (genvar gi = 0; gi < N; gi++) begin : g_elem
    always_ff @(posedge clk) begin
      if (!rstN) begin
        arrV[gi] <= 1'b0;
      end else if (strobe.clearArr) begin
        arrV[gi] <= 1'b0;
      end else if (strobe.recordArr && syncReq[gi]) begin
        arrV[gi] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        doneV[gi] <= 1'b0;
      end else if (strobe.clearDone) begin
        doneV[gi] <= 1'b0;
      end else if (strobe.recordDone && xchgDone[gi]) begin
        doneV[gi] <= 1'b1;
      end
    end

    assign dupHit[gi] = strobe.recordArr & syncReq[gi] & arrV[gi];
  end

  assign anyReq     = |syncReq;
  assign allArrived = &arrV;
  assign allDone    = &doneV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCount <= '0;
    end else if (strobe.bumpStep) begin
      stepCount <= stepCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoErr <= 1'b0;
    end else if (|dupHit) begin
      protoErr <= 1'b1;
    end
  end

endmodule

// File: rtl/bsp_seq_ctrl.sv
module bsp_seq_ctrl
  import bsp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       allArrived,
  input  logic       allDone,
  output seqStrobe_t strobe,
  output phase_e     phase,
  output logic       startCompute
);

  phase_e state;
  phase_e nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      PH_COMPUTE: begin
        strobe.recordArr = 1'b1;
        if (anyReq) nextState = PH_SYNC;
      end
      PH_SYNC: begin
        strobe.recordArr = 1'b1;
        if (allArrived) begin
          strobe.clearArr = 1'b1;
          nextState       = PH_EXCHANGE;
        end
      end
      PH_EXCHANGE: begin
        strobe.recordDone = 1'b1;
        if (allDone) begin
          strobe.clearDone = 1'b1;
          strobe.bumpStep  = 1'b1;
          nextState        = PH_COMPUTE;
        end
      end
      default: nextState = PH_COMPUTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= PH_COMPUTE;
      startCompute <= 1'b0;
    end else begin
      state        <= nextState;
      startCompute <= (state == PH_EXCHANGE) && allDone;
    end
  end

  assign phase = state;

endmodule

// File: rtl/bsp_phase_seq.sv
module bsp_phase_seq
  import bsp_seq_pkg::*;
#(
  parameter int N      = 8,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      syncReq,
  input  logic [N-1:0]      xchgDone,
  output logic [1:0]        phase,
  output logic              startCompute,
  output logic [STEP_W-1:0] stepCount,
  output logic              protoErr
);

  seqStrobe_t strobe;
  phase_e     phaseInt;
  logic       anyReq;
  logic       allArrived;
  logic       allDone;

  bsp_seq_ctrl ctrlInst (
    .clk          (clk),
    .rstN         (rstN),
    .anyReq       (anyReq),
    .allArrived   (allArrived),
    .allDone      (allDone),
    .strobe       (strobe),
    .phase        (phaseInt),
    .startCompute (startCompute)
  );

  bsp_seq_datapath #(.N(N), .STEP_W(STEP_W)) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .syncReq    (syncReq),
    .xchgDone   (xchgDone),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .allArrived (allArrived),
    .allDone    (allDone),
    .stepCount  (stepCount),
    .protoErr   (protoErr)
  );

  assign phase = phaseInt;

endmodule

// File: rtl/bsp_phase_seq_chk.sv
module bsp_phase_seq_chk #(
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phase,
  input logic              startCompute,
  input logic [STEP_W-1:0] stepCount,
  input logic              protoErr
);

  // R2
  legal_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase != 2'd3);

  // R9
  exch_from_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1);

  // R6
  start_after_exch_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCompute |-> (phase == 2'd0 && $past(phase) == 2'd2));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCompute |=> !startCompute);

  // R7
  step_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepCount != $past(stepCount)) |-> startCompute);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

bind bsp_phase_seq bsp_phase_seq_chk #(.STEP_W(STEP_W)) chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .phase        (phase),
  .startCompute (startCompute),
  .stepCount    (stepCount),
  .protoErr     (protoErr)
);

// File: tb/bsp_phase_seq_test.sv
`timescale 1ns/1ps
module bsp_phase_seq_test;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  syncReq = '0;
  logic [N-1:0]  xchgDone = '0;
  logic [1:0]    phase;
  logic          startCompute;
  logic [15:0]   stepCount;
  logic          protoErr;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  bsp_phase_seq #(.N(N), .STEP_W(16)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .syncReq      (syncReq),
    .xchgDone     (xchgDone),
    .phase        (phase),
    .startCompute (startCompute),
    .stepCount    (stepCount),
    .protoErr     (protoErr)
  );

  typedef struct packed {
    logic [3:0]  req;   // requirement number for the message
    logic [3:0]  s;
    logic [3:0]  x;
    logic [1:0]  ph;
    logic        st;
    logic [15:0] step;
    logic        err;
  } vec_t;

  // inputs during one cycle, outputs expected after that edge
  localparam vec_t TBL [20] = '{
    '{4'd2, 4'b0001, 4'b0000, 2'd1, 1'b0, 16'd0, 1'b0}, // R2 first arrival
    '{4'd3, 4'b0100, 4'b0000, 2'd1, 1'b0, 16'd0, 1'b0}, // R3
    '{4'd3, 4'b0000, 4'b0000, 2'd1, 1'b0, 16'd0, 1'b0}, // R3 holds
    '{4'd3, 4'b1010, 4'b0000, 2'd1, 1'b0, 16'd0, 1'b0}, // R3 vector full
    '{4'd3, 4'b0000, 4'b0000, 2'd2, 1'b0, 16'd0, 1'b0}, // R3 release
    '{4'd5, 4'b0000, 4'b0011, 2'd2, 1'b0, 16'd0, 1'b0}, // R5 partial
    '{4'd4, 4'b1111, 4'b1100, 2'd2, 1'b0, 16'd0, 1'b0}, // R4 sync ignored
    '{4'd6, 4'b0000, 4'b0000, 2'd0, 1'b1, 16'd1, 1'b0}, // R6 pulse
    '{4'd6, 4'b0000, 4'b0000, 2'd0, 1'b0, 16'd1, 1'b0}, // R6 one cycle
    '{4'd5, 4'b1111, 4'b1111, 2'd1, 1'b0, 16'd1, 1'b0}, // R5 done ignored
    '{4'd3, 4'b0000, 4'b0000, 2'd2, 1'b0, 16'd1, 1'b0}, // R3
    '{4'd5, 4'b0000, 4'b1111, 2'd2, 1'b0, 16'd1, 1'b0}, // R5
    '{4'd7, 4'b0000, 4'b0000, 2'd0, 1'b1, 16'd2, 1'b0}, // R7
    '{4'd4, 4'b0001, 4'b0000, 2'd1, 1'b0, 16'd2, 1'b0}, // R4 no stale bits
    '{4'd4, 4'b0000, 4'b0000, 2'd1, 1'b0, 16'd2, 1'b0}, // R4
    '{4'd3, 4'b1110, 4'b0000, 2'd1, 1'b0, 16'd2, 1'b0}, // R3
    '{4'd3, 4'b0000, 4'b0000, 2'd2, 1'b0, 16'd2, 1'b0}, // R3
    '{4'd5, 4'b0000, 4'b0000, 2'd2, 1'b0, 16'd2, 1'b0}, // R5 waits
    '{4'd5, 4'b0000, 4'b1111, 2'd2, 1'b0, 16'd2, 1'b0}, // R5
    '{4'd7, 4'b0000, 4'b0000, 2'd0, 1'b1, 16'd3, 1'b0}  // R7
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [1:0] ph, input logic st,
                        input logic [15:0] step, input logic err);
    chk(req, "phase", {30'd0, phase}, {30'd0, ph});
    chk(req, "startCompute", {31'd0, startCompute}, {31'd0, st});
    chk(req, "stepCount", {16'd0, stepCount}, {16'd0, step});
    chk(req, "protoErr", {31'd0, protoErr}, {31'd0, err});
  endtask

  task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] x);
    syncReq  = s;
    xchgDone = x;
    @(posedge clk);
    @(negedge clk);
    syncReq  = '0;
    xchgDone = '0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkAll("R1", 2'd0, 1'b0, 16'd0, 1'b0);

    for (int i = 0; i < 20; i++) begin
      cyc(TBL[i].s, TBL[i].x);
      chkAll($sformatf("R%0d row%0d", TBL[i].req, i), TBL[i].ph, TBL[i].st,
             TBL[i].step, TBL[i].err);
    end

    // R8 duplicate request while pending
    cyc(4'b0001, 4'b0000);
    chkAll("R8", 2'd1, 1'b0, 16'd3, 1'b0);
    cyc(4'b0001, 4'b0000);
    chkAll("R8", 2'd1, 1'b0, 16'd3, 1'b1);
    cyc(4'b1110, 4'b0000);
    chkAll("R8", 2'd1, 1'b0, 16'd3, 1'b1);
    cyc(4'b0000, 4'b0000);
    chkAll("R8", 2'd2, 1'b0, 16'd3, 1'b1);
    cyc(4'b0000, 4'b1111);
    cyc(4'b0000, 4'b0000);
    chkAll("R8", 2'd0, 1'b1, 16'd4, 1'b1);

    // R1 reset mid-run clears everything
    rstN = 1'b0;
    cyc(4'b0000, 4'b0000);
    cyc(4'b0000, 4'b0000);
    rstN = 1'b1;
    chkAll("R1", 2'd0, 1'b0, 16'd0, 1'b0);

    // R8 duplicate in the release cycle
    cyc(4'b1111, 4'b0000);
    chkAll("R8", 2'd1, 1'b0, 16'd0, 1'b0);
    cyc(4'b0001, 4'b0000);
    chkAll("R8", 2'd2, 1'b0, 16'd0, 1'b1);

    // R9 exchange waits for every element, one at a time
    for (int k = 0; k < N; k++) begin
      chk("R9", "phase before last done", {30'd0, phase}, 32'd2);
      cyc(4'(1 << k), 4'b0000);
      cyc(4'b0000, 4'(1 << k));
    end
    cyc(4'b0000, 4'b0000);
    chkAll("R9", 2'd0, 1'b1, 16'd1, 1'b1);

    finishRun();
  end

endmodule